// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It walks a two-level page table held in ordinary memory. The caller places a virtual address, an access kind (read or write) and the page-table base on the request port, holds the request valid, and waits for a one-cycle done pulse. The walker then reads the first-level entry and the second-level (leaf) entry over a single-word memory port. It checks the valid bit of each entry. It returns either the translated address or a page-fault indication.

The virtual address splits into three fields. The top ten bits (31:22) index the first-level table. The next ten bits (21:12) index the second-level table. The low twelve bits are the byte offset within a 4 KB page. Every entry is one 32-bit word, so each table holds 1024 entries in 4 KB. An entry stores its frame number in bits 31:12, a dirty flag in bit 2, a referenced flag in bit 1 and a present flag in bit 0. On a successful walk the leaf is marked referenced, and also dirty when the access is a write. The walker writes the leaf back in one extra memory cycle, but only when one of those flags actually changes.

The memory port has a fixed latency: read data is valid in the cycle after the read strobe. A write completes in the cycle in which the write strobe is high.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and in the cycle after it, req_ready is 1 and done, fault, mem_rd_en and mem_wr_en are 0.
- R2: A request is accepted only when req_ready is 1. From the cycle after acceptance through the done cycle, req_ready stays 0, and a req_valid raised in that time starts no memory access.
- R3: In the first cycle after acceptance, mem_rd_en is 1 and mem_addr equals the base sampled at acceptance plus 4 × vaddr[31:22].
- R4: The second read, two cycles after the first, uses the address {first-level entry bits 31:12, 12'h000} + 4 × vaddr[21:12].
- R5: When the first-level entry has bit 0 clear, done and fault are 1 three cycles after acceptance, paddr is 0, and no second read or write occurs.
- R6: When the leaf entry has bit 0 clear, done and fault are 1 five cycles after acceptance, paddr is 0, and no write occurs.
- R7: On a successful walk, fault is 0 and paddr equals {leaf bits 31:12, vaddr[11:0]} in the done cycle.
- R8: When a present leaf has bit 1 clear, the walker writes the leaf word back to the leaf address with bit 1 set and all other bits unchanged.
- R9: For a write request, the written-back leaf also has bit 2 set.
- R10: When neither flag would change, no write occurs and done comes five cycles after acceptance. With a write-back, done comes six cycles after acceptance, in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store (sets the dirty flag) |
| ptbr | input | 32 | Base address of the first-level table |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Byte address of the entry word |
| mem_wdata | output | 32 | Updated leaf entry for write-back |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd_en |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Page fault, valid with done |
| paddr | output | 32 | Translated physical address, valid with done |

## Verification
Take the edge at which req_valid meets req_ready as cycle 0. The first read is due in cycle 1 and the second in cycle 3. A first-level fault completes in cycle 3. A leaf fault or a clean hit completes in cycle 5. A walk that writes back strobes the write in cycle 5 and completes in cycle 6. The bench drives inputs at falling edges and counts falling edges from acceptance until done, then compares that count with 3, 5 or 6 exactly. A memory model logs the address of every strobe and the data of every write, so the bench checks the order and content of the accesses separately from the response.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    localparam int ADDR_W  = 32;
    localparam int IDX_W   = 10;
    localparam int OFF_W   = 12;
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int ENT_SH  = 2;            // 4-byte entries

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [OFF_W-4:0]   avail;
        logic               dirty;
        logic               refd;
        logic               valid;
    } pte_t;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_L1_RD,
        WS_L1_CHK,
        WS_L2_RD,
        WS_L2_CHK,
        WS_WBACK,
        WS_RESP
    } walk_st_e;

    function automatic pte_t mark_access(input pte_t e, input logic is_wr);
        pte_t r;
        r       = e;
        r.refd  = 1'b1;
        if (is_wr) r.dirty = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int AW  = 32,
    parameter int IW  = 10,
    parameter int OW  = 12,
    parameter int ESH = 2
) (
    input  logic [AW-1:0] root_base,
    input  logic [AW-1:0] leaf_base,
    input  logic [AW-1:0] vaddr,
    input  logic          sel_leaf,
    output logic [AW-1:0] ent_addr
);
    localparam int HI_LSB = AW - IW;

    logic [IW-1:0] idx_top;
    logic [IW-1:0] idx_mid;
    logic [AW-1:0] ofs_top;
    logic [AW-1:0] ofs_mid;

    assign idx_top = vaddr[HI_LSB +: IW];
    assign idx_mid = vaddr[OW +: IW];
    assign ofs_top = AW'(idx_top) << ESH;
    assign ofs_mid = AW'(idx_mid) << ESH;

    always_comb begin
        if (sel_leaf) ent_addr = leaf_base + ofs_mid;
        else          ent_addr = root_base + ofs_top;
    end
endmodule

// File: rtl/pt_leaf_mark.sv
module pt_leaf_mark
    import pt_walk_pkg::*;
(
    input  pte_t leaf_in,
    input  logic is_wr,
    output pte_t leaf_out,
    output logic changed
);
    always_comb begin
        leaf_out = mark_access(leaf_in, is_wr);
        changed  = (leaf_out != leaf_in);
    end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
    import pt_walk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     ent_present,
    input  logic     leaf_changed,
    output walk_st_e st,
    output logic     faulted
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= WS_IDLE;
            faulted <= 1'b0;
        end else begin
            unique case (st)
                WS_IDLE: begin
                    if (start) begin
                        st      <= WS_L1_RD;
                        faulted <= 1'b0;
                    end
                end
                WS_L1_RD:  st <= WS_L1_CHK;
                WS_L1_CHK: begin
                    if (!ent_present) begin
                        faulted <= 1'b1;
                        st      <= WS_RESP;
                    end else begin
                        st <= WS_L2_RD;
                    end
                end
                WS_L2_RD:  st <= WS_L2_CHK;
                WS_L2_CHK: begin
                    if (!ent_present) begin
                        faulted <= 1'b1;
                        st      <= WS_RESP;
                    end else if (leaf_changed) begin
                        st <= WS_WBACK;
                    end else begin
                        st <= WS_RESP;
                    end
                end
                WS_WBACK:  st <= WS_RESP;
                WS_RESP:   st <= WS_IDLE;
                default:   st <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] ptbr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [ADDR_W-1:0] paddr
);
    walk_st_e           st;
    logic               faulted;
    logic               start;
    pte_t               rd_pte;
    pte_t               marked;
    logic               changed;

    logic [ADDR_W-1:0]  va_q;
    logic               wr_q;
    logic [ADDR_W-1:0]  base_q;
    logic [FRAME_W-1:0] l1_frame_q;
    pte_t               leaf_q;
    logic [ADDR_W-1:0]  paddr_q;
    logic [ADDR_W-1:0]  leaf_tbl;

    assign start    = req_valid && (st == WS_IDLE);
    assign rd_pte   = pte_t'(mem_rdata);
    assign leaf_tbl = {l1_frame_q, {OFF_W{1'b0}}};

    pt_walk_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .ent_present  (rd_pte.valid),
        .leaf_changed (changed),
        .st           (st),
        .faulted      (faulted)
    );

    pt_entry_addr #(
        .AW  (ADDR_W),
        .IW  (IDX_W),
        .OW  (OFF_W),
        .ESH (ENT_SH)
    ) u_addr (
        .root_base (base_q),
        .leaf_base (leaf_tbl),
        .vaddr     (va_q),
        .sel_leaf  (st != WS_L1_RD),
        .ent_addr  (mem_addr)
    );

    pt_leaf_mark u_mark (
        .leaf_in  (rd_pte),
        .is_wr    (wr_q),
        .leaf_out (marked),
        .changed  (changed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q       <= '0;
            wr_q       <= 1'b0;
            base_q     <= '0;
            l1_frame_q <= '0;
            leaf_q     <= '0;
            paddr_q    <= '0;
        end else begin
            if (start) begin
                va_q    <= req_vaddr;
                wr_q    <= req_write;
                base_q  <= ptbr;
                paddr_q <= '0;
            end
            if (st == WS_L1_CHK) l1_frame_q <= rd_pte.frame;
            if (st == WS_L2_CHK) begin
                leaf_q <= marked;
                if (rd_pte.valid) paddr_q <= {rd_pte.frame, va_q[OFF_W-1:0]};
            end
        end
    end

    assign req_ready = (st == WS_IDLE);
    assign mem_rd_en = (st == WS_L1_RD) || (st == WS_L2_RD);
    assign mem_wr_en = (st == WS_WBACK);
    assign mem_wdata = leaf_q;
    assign done      = (st == WS_RESP);
    assign fault     = done && faulted;
    assign paddr     = paddr_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        req_write,
    input logic [31:0] ptbr,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        done,
    input logic        fault,
    input logic [31:0] paddr
);
    logic [11:0] off_cap;
    logic        wr_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_cap <= '0;
            wr_cap  <= 1'b0;
        end else if (req_valid && req_ready) begin
            off_cap <= req_vaddr[11:0];
            wr_cap  <= req_write;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !done && !fault && !mem_rd_en && !mem_wr_en));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    done_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_ready);

    // R3
    first_read_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (mem_rd_en &&
            mem_addr == $past(ptbr) + {20'd0, $past(req_vaddr[31:22]), 2'b00}));

    // R5
    fault_only_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    // R6
    fault_zero_paddr_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (paddr == 32'd0));

    // R7
    offset_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (paddr[11:0] == off_cap));

    // R8
    wb_ref_set_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_wdata[1] && mem_wdata[0] && !mem_rd_en));

    // R9
    wb_dirty_set_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && wr_cap) |-> mem_wdata[2]);

    // R10
    wb_then_done_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> (done && !fault));
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .req_write (req_write),
    .ptbr      (ptbr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .fault     (fault),
    .paddr     (paddr)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] ptbr = '0;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, fault;
    logic [31:0] paddr;

    int total = 0;
    int bad   = 0;

    logic [31:0] mem [0:2047];
    int          rd_cnt, wr_cnt;
    logic [31:0] rd_a0, rd_a1, wr_a, wr_d;

    always #5 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .ptbr(ptbr),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .paddr(paddr)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[12:2]];
            if (rd_cnt == 0) rd_a0 <= mem_addr;
            if (rd_cnt == 1) rd_a1 <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
        if (mem_wr_en) begin
            mem[mem_addr[12:2]] <= mem_wdata;
            wr_a   <= mem_addr;
            wr_d   <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mkva(input int i1, input int i2, input int off);
        return {i1[9:0], i2[9:0], off[11:0]};
    endfunction

    task automatic walk(input logic [31:0] va, input logic wr, input logic [31:0] base,
                        input bit hold, output int cyc);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        rd_a0 = '0; rd_a1 = '0; wr_a = '0; wr_d = '0;
        req_vaddr = va; req_write = wr; ptbr = base; req_valid = 1'b1;
        @(negedge clk);
        cyc = 1;
        if (hold) req_vaddr = mkva(9, 9, 0);
        else      req_valid = 1'b0;
        while (!done && cyc < 20) begin
            chk(req_ready == 1'b0, "R2 busy ready", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            cyc++;
        end
        chk(req_ready == 1'b0, "R2 done ready", {31'd0, req_ready}, 32'd0);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready && !done && !fault && !mem_rd_en && !mem_wr_en, "R1 reset outputs",
            {27'd0, req_ready, done, fault, mem_rd_en, mem_wr_en}, 32'h10);
    endtask

    task automatic t_clean_hit;
        int c;
        walk(mkva(5, 7, 'h9A4), 1'b0, 32'h1000, 1'b0, c);
        chk(c == 5, "R10 clean hit latency", c, 5);
        chk(rd_cnt == 2 && wr_cnt == 0, "R10 no write", {rd_cnt[15:0], wr_cnt[15:0]}, 32'h0002_0000);
        chk(rd_a0 == 32'h1014, "R3 first read addr", rd_a0, 32'h1014);
        chk(rd_a1 == 32'hABCDE01C, "R4 leaf read addr", rd_a1, 32'hABCDE01C);
        chk(!fault && paddr == 32'h55AA39A4, "R7 paddr", paddr, 32'h55AA39A4);
    endtask

    task automatic t_ref_set;
        int c;
        walk(mkva(5, 8, 'h010), 1'b0, 32'h1000, 1'b0, c);
        chk(c == 6, "R10 writeback latency", c, 6);
        chk(wr_cnt == 1 && wr_a == 32'hABCDE020, "R8 wb addr", wr_a, 32'hABCDE020);
        chk(wr_d == 32'h0F0F0003, "R8 wb data ref set", wr_d, 32'h0F0F0003);
        chk(paddr == 32'h0F0F0010, "R7 paddr after wb", paddr, 32'h0F0F0010);
    endtask

    task automatic t_dirty;
        int c;
        walk(mkva(5, 9, 'hFFF), 1'b1, 32'h1000, 1'b0, c);
        chk(c == 6 && wr_cnt == 1, "R9 store writes back", c, 6);
        chk(wr_d == 32'h13579007, "R9 wb data dirty set", wr_d, 32'h13579007);
        walk(mkva(5, 9, 'h000), 1'b1, 32'h1000, 1'b0, c);
        chk(c == 5 && wr_cnt == 0, "R10 second store no wb", wr_cnt, 0);
        chk(paddr == 32'h13579000, "R7 offset zero", paddr, 32'h13579000);
    endtask

    task automatic t_l1_fault;
        int c;
        walk(mkva(6, 7, 'h123), 1'b0, 32'h1000, 1'b0, c);
        chk(c == 3, "R5 fault latency", c, 3);
        chk(fault && paddr == 0, "R5 fault flag paddr", paddr, 0);
        chk(rd_cnt == 1 && wr_cnt == 0, "R5 single read", rd_cnt, 1);
    endtask

    task automatic t_l2_fault;
        int c;
        walk(mkva(5, 10, 'h456), 1'b1, 32'h1000, 1'b0, c);
        chk(c == 5, "R6 fault latency", c, 5);
        chk(fault && paddr == 0, "R6 fault flag paddr", paddr, 0);
        chk(rd_cnt == 2 && wr_cnt == 0, "R6 no write", wr_cnt, 0);
    endtask

    task automatic t_busy;
        int c;
        walk(mkva(5, 7, 'h001), 1'b0, 32'h1000, 1'b1, c);
        chk(c == 5 && rd_cnt == 2, "R2 walk unaffected", rd_cnt, 2);
        chk(rd_a0 == 32'h1014 && rd_a1 == 32'hABCDE01C, "R2 addresses from first req",
            rd_a1, 32'hABCDE01C);
        @(negedge clk);
        @(negedge clk);
        chk(rd_cnt == 2 && req_ready, "R2 no extra walk", rd_cnt, 2);
    endtask

    task automatic t_base;
        int c;
        walk(mkva(3, 11, 'h0FF), 1'b0, 32'h1800, 1'b0, c);
        chk(rd_a0 == 32'h180C, "R3 other base", rd_a0, 32'h180C);
        chk(rd_a1 == 32'hABCDE02C, "R4 other index", rd_a1, 32'hABCDE02C);
        chk(c == 5 && paddr == 32'h7E7E70FF, "R7 other base paddr", paddr, 32'h7E7E70FF);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        rd_cnt = 0; wr_cnt = 0;
        mem[32'h1014 >> 2] = 32'hABCDE001;
        mem[32'h1018 >> 2] = 32'hABCDE000;
        mem[32'h180C >> 2] = 32'hABCDE001;
        mem[7]  = 32'h55AA3003;
        mem[8]  = 32'h0F0F0001;
        mem[9]  = 32'h13579003;
        mem[10] = 32'h22222002;
        mem[11] = 32'h7E7E7003;
        repeat (3) @(posedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_clean_hit;
        t_ref_set;
        t_dirty;
        t_l1_fault;
        t_l2_fault;
        t_busy;
        t_base;
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule